// File: doc/BRIEF.md
# PCI Host Bridge Register Interface

This block is the register front end of a PCI host controller. A CPU reaches it over a simple 32-bit register bus. The block holds the host's own 256-byte configuration header as sixty-four 32-bit words, and three control registers. The first control register is a pointer that addresses configuration space. The second is a memory base and the third is an I/O base. Each control register masks its writable bits in its own way.

A register-bus access to the data port does not touch local state. It becomes a configuration request toward the PCI side, addressed by the pointer. The CPU is stalled through the ready signal until the PCI side acknowledges, and a read returns the data delivered with that acknowledge.

The block also decodes a movable 256 KB I/O window whose base is the upper bits of the I/O base register. For any address presented on the window lookup port, it reports a hit and the offset inside the window. Finally, it folds per-function device interrupt lines onto four interrupt outputs, selected by device number.

Top module: `pcihb_regif`

## Requirements
- R1: After reset the pointer reads 0x00000000, the memory base reads 0x00000000 and the I/O base reads 0xFE240000. Header word 0 (offset 0x000) reads {DEVICE_ID, VENDOR_ID}, with the vendor in bits 15:0. Header word 1 (offset 0x004) reads 0x02900080: the command half has the wait-cycle bit (bit 7) set, and the status half has bit 4, bit 7 and DEVSEL timing bits 10:9 = 01 set.
- R2: An aligned access to offsets 0x000 to 0x0FC reads or writes a full 32-bit header word. The word index is address bits 7:2.
- R3: Offset 0x1C0 is the configuration pointer. It stores and returns all 32 written bits.
- R4: Offset 0x1C4 is the memory base. A write keeps bits 31:24 and bit 0, and every other bit reads as zero.
- R5: Offset 0x1C8 is the I/O base. A write keeps bits 31:18 and bit 0, and every other bit reads as zero.
- R6: An access to offset 0x220 raises cfgReq on the cycle after the access is presented. While cfgReq is high, cfgAddr carries the pointer value, cfgWrite is 1 for a write and 0 for a read, and cfgWdata carries the written data. cfgReq stays high until the cycle in which cfgAck is high.
- R7: During a data-port access, busReady stays low until the cycle after cfgAck. The total latency is (cycles from request to acknowledge) + 2. A data-port read returns the cfgRdata value present with cfgAck.
- R8: Every access other than an aligned data-port access completes with busReady high in the cycle it is presented.
- R9: Reads of undecoded or misaligned offsets (address bits 1:0 not zero) return zero. Writes to them change no register. This covers 0x100 to 0x1BF, 0x1CC to 0x21F, offsets above 0x220, and misaligned offsets.
- R10: winHit is high exactly when winAddr bits 31:18 equal I/O base bits 31:18. winOffset is winAddr bits 17:0. The window follows an I/O base write from the next cycle.
- R11: Interrupt input devIrq[8*d+f] belongs to device d, function f. It drives intOut[d mod 4], and each output is the OR of the lines routed to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access request, held until busReady |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset in the register space |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busReady |
| busReady | output | 1 | Access completes at this clock edge |
| cfgReq | output | 1 | Configuration request toward the PCI side |
| cfgWrite | output | 1 | Configuration request direction |
| cfgAddr | output | 32 | Configuration address (pointer value) |
| cfgWdata | output | 32 | Configuration write data |
| cfgAck | input | 1 | PCI side completes the request |
| cfgRdata | input | 32 | Configuration read data, valid with cfgAck |
| winAddr | input | 32 | Address checked against the I/O window |
| winHit | output | 1 | winAddr lies inside the I/O window |
| winOffset | output | WIN_BITS | Offset of winAddr inside the window |
| devIrq | input | 8*NUM_DEV | Per-function interrupt lines |
| intOut | output | 4 | Routed interrupt outputs |

## Verification
The bench builds the block with NUM_DEV = 6 rather than the default of 4. This places devices 4 and 5 on the interrupt inputs, so the wrap of the device number onto the four outputs is exercised and is not hidden behind a one-to-one mapping. The other parameters stay at their defaults, with the 18-bit window and the 0xFE240000 I/O base. This lets the bench probe window edges at the reset base and after a move. The PCI responder's acknowledge delay is varied between accesses, so the ready latency is checked for more than one wait length.

// File: rtl/pcihb_pkg.sv
package pcihb_pkg;

  localparam logic [11:0] OFS_HDR_END = 12'h100;
  localparam logic [11:0] OFS_PTR     = 12'h1C0;
  localparam logic [11:0] OFS_MEM     = 12'h1C4;
  localparam logic [11:0] OFS_IO      = 12'h1C8;
  localparam logic [11:0] OFS_PORT    = 12'h220;

  localparam logic [31:0] MEM_KEEP = 32'hFF00_0001;

  // reset value of header word 1: status in the upper half, command in the lower half
  localparam logic [15:0] CMD_RESET  = 16'h0080;
  localparam logic [15:0] STAT_RESET = 16'h0290;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } portState_e;

  typedef enum logic [2:0] {
    RD_ZERO = 3'd0,
    RD_HDR  = 3'd1,
    RD_PTR  = 3'd2,
    RD_MEM  = 3'd3,
    RD_IO   = 3'd4,
    RD_PORT = 3'd5
  } rdSel_e;

  typedef struct packed {
    logic   hdrWr;
    logic   ptrWr;
    logic   memWr;
    logic   ioWr;
    logic   portStart;
    logic   portLoad;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/pcihb_ctrl.sv
module pcihb_ctrl
  import pcihb_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              busReady,
  output logic              cfgReq,
  output logic              cfgWrite,
  input  logic              cfgAck,
  output strobe_t           strb
);

  portState_e state, stateNext;

  logic aligned, hdrHit, ptrHit, memHit, ioHit, portHit, acc;

  always_comb begin
    aligned = (busAddr[1:0] == 2'b00);
    hdrHit  = aligned && (busAddr < ADDR_W'(OFS_HDR_END));
    ptrHit  = aligned && (busAddr == ADDR_W'(OFS_PTR));
    memHit  = aligned && (busAddr == ADDR_W'(OFS_MEM));
    ioHit   = aligned && (busAddr == ADDR_W'(OFS_IO));
    portHit = aligned && (busAddr == ADDR_W'(OFS_PORT));
    acc     = busSel && (state == ST_IDLE);
  end

  always_comb begin
    strb.hdrWr     = acc && busWrite && hdrHit;
    strb.ptrWr     = acc && busWrite && ptrHit;
    strb.memWr     = acc && busWrite && memHit;
    strb.ioWr      = acc && busWrite && ioHit;
    strb.portStart = acc && portHit;
    strb.portLoad  = (state == ST_WAIT) && cfgAck;
    if (state == ST_DONE)  strb.rdSel = RD_PORT;
    else if (hdrHit)       strb.rdSel = RD_HDR;
    else if (ptrHit)       strb.rdSel = RD_PTR;
    else if (memHit)       strb.rdSel = RD_MEM;
    else if (ioHit)        strb.rdSel = RD_IO;
    else                   strb.rdSel = RD_ZERO;
  end

  always_comb begin
    busReady = (acc && !portHit) || (state == ST_DONE);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (strb.portStart) stateNext = ST_WAIT;
      ST_WAIT: if (cfgAck)         stateNext = ST_DONE;
      ST_DONE:                     stateNext = ST_IDLE;
      default:                     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cfgReq   <= 1'b0;
      cfgWrite <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.portStart) begin
        cfgReq   <= 1'b1;
        cfgWrite <= busWrite;
      end else if (strb.portLoad) begin
        cfgReq <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pcihb_dp.sv
module pcihb_dp
  import pcihb_pkg::*;
#(
  parameter int          NUM_DEV   = 4,
  parameter int          WIN_BITS  = 18,
  parameter logic [15:0] VENDOR_ID = 16'h1DE5,
  parameter logic [15:0] DEVICE_ID = 16'hC0DE,
  parameter logic [31:0] IO_RESET  = 32'hFE24_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [5:0]            hdrIdx,
  input  logic [31:0]           busWdata,
  output logic [31:0]           busRdata,
  output logic [31:0]           cfgAddr,
  output logic [31:0]           cfgWdata,
  input  logic [31:0]           cfgRdata,
  input  logic [31:0]           winAddr,
  output logic                  winHit,
  output logic [WIN_BITS-1:0]   winOffset,
  input  logic [8*NUM_DEV-1:0]  devIrq,
  output logic [3:0]            intOut
);

  localparam int          HDR_WORDS = 64;
  localparam int          NUM_INT   = 4;
  localparam int          FN_PER_DEV = 8;
  localparam logic [31:0] IO_KEEP   = {{(32-WIN_BITS){1'b1}}, {(WIN_BITS-1){1'b0}}, 1'b1};

  logic [31:0] hdrMem [HDR_WORDS];
  logic [31:0] ptrReg, memReg, ioReg, portData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < HDR_WORDS; w++) hdrMem[w] <= '0;
      hdrMem[0] <= {DEVICE_ID, VENDOR_ID};
      hdrMem[1] <= {STAT_RESET, CMD_RESET};
    end else if (strb.hdrWr) begin
      hdrMem[hdrIdx] <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrReg   <= '0;
      memReg   <= '0;
      ioReg    <= IO_RESET & IO_KEEP;
      cfgWdata <= '0;
      portData <= '0;
    end else begin
      if (strb.ptrWr)     ptrReg   <= busWdata;
      if (strb.memWr)     memReg   <= busWdata & MEM_KEEP;
      if (strb.ioWr)      ioReg    <= busWdata & IO_KEEP;
      if (strb.portStart) cfgWdata <= busWdata;
      if (strb.portLoad)  portData <= cfgRdata;
    end
  end

  assign cfgAddr = ptrReg;

  always_comb begin
    unique case (strb.rdSel)
      RD_HDR:  busRdata = hdrMem[hdrIdx];
      RD_PTR:  busRdata = ptrReg;
      RD_MEM:  busRdata = memReg;
      RD_IO:   busRdata = ioReg;
      RD_PORT: busRdata = portData;
      default: busRdata = '0;
    endcase
  end

  // movable I/O window: compare the upper address bits against the base
  always_comb begin
    winHit    = (winAddr[31:WIN_BITS] == ioReg[31:WIN_BITS]);
    winOffset = winAddr[WIN_BITS-1:0];
  end

  // interrupt folding: device d lands on output d mod NUM_INT
  for (genvar k = 0; k < NUM_INT; k++) begin : g_int
    logic lineOr;
    always_comb begin
      lineOr = 1'b0;
      for (int d = 0; d < NUM_DEV; d++) begin
        if ((d % NUM_INT) == k) lineOr = lineOr | (|devIrq[d*FN_PER_DEV +: FN_PER_DEV]);
      end
    end
    assign intOut[k] = lineOr;
  end

endmodule

// File: rtl/pcihb_regif.sv
module pcihb_regif
  import pcihb_pkg::*;
#(
  parameter int          ADDR_W    = 10,
  parameter int          NUM_DEV   = 4,
  parameter int          WIN_BITS  = 18,
  parameter logic [15:0] VENDOR_ID = 16'h1DE5,
  parameter logic [15:0] DEVICE_ID = 16'hC0DE,
  parameter logic [31:0] IO_RESET  = 32'hFE24_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic                 busReady,
  output logic                 cfgReq,
  output logic                 cfgWrite,
  output logic [31:0]          cfgAddr,
  output logic [31:0]          cfgWdata,
  input  logic                 cfgAck,
  input  logic [31:0]          cfgRdata,
  input  logic [31:0]          winAddr,
  output logic                 winHit,
  output logic [WIN_BITS-1:0]  winOffset,
  input  logic [8*NUM_DEV-1:0] devIrq,
  output logic [3:0]           intOut
);

  strobe_t strb;

  pcihb_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busReady (busReady),
    .cfgReq   (cfgReq),
    .cfgWrite (cfgWrite),
    .cfgAck   (cfgAck),
    .strb     (strb)
  );

  pcihb_dp #(
    .NUM_DEV   (NUM_DEV),
    .WIN_BITS  (WIN_BITS),
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID),
    .IO_RESET  (IO_RESET)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .hdrIdx    (busAddr[7:2]),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .cfgAddr   (cfgAddr),
    .cfgWdata  (cfgWdata),
    .cfgRdata  (cfgRdata),
    .winAddr   (winAddr),
    .winHit    (winHit),
    .winOffset (winOffset),
    .devIrq    (devIrq),
    .intOut    (intOut)
  );

endmodule

// File: rtl/pcihb_checker.sv
module pcihb_checker #(
  parameter int ADDR_W  = 10,
  parameter int NUM_DEV = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busSel,
  input logic                 busWrite,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [31:0]          busRdata,
  input logic                 busReady,
  input logic                 cfgReq,
  input logic [31:0]          cfgAddr,
  input logic                 cfgAck,
  input logic [31:0]          cfgRdata,
  input logic [8*NUM_DEV-1:0] devIrq,
  input logic [3:0]           intOut
);

  logic rdDone;
  assign rdDone = busSel && busReady && !busWrite;

  // R6: the request is held until it is acknowledged
  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq && !cfgAck |=> cfgReq);

  // R6: the configuration address does not move while a request waits
  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq && !cfgAck |=> $stable(cfgAddr));

  // R6: a request only drops after an acknowledge
  assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgReq) |-> $past(cfgAck));

  // R7: a completed data-port read returns the acknowledged data
  assert_port_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdDone && (busAddr == ADDR_W'(12'h220)) |-> $past(cfgAck) && (busRdata == $past(cfgRdata)));

  // R8: any access except the data port completes at once
  assert_fast_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    busSel && (busAddr != ADDR_W'(12'h220)) |-> busReady);

  // R4: unkept memory-base bits read as zero
  assert_mem_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdDone && (busAddr == ADDR_W'(12'h1C4)) |-> (busRdata & 32'h00FF_FFFE) == 32'h0);

  // R5: unkept I/O-base bits read as zero
  assert_io_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdDone && (busAddr == ADDR_W'(12'h1C8)) |-> (busRdata & 32'h0003_FFFE) == 32'h0);

  // R9: the hole above the header reads as zero
  assert_hole_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdDone && (busAddr >= ADDR_W'(12'h100)) && (busAddr < ADDR_W'(12'h1C0)) |-> busRdata == 32'h0);

  // R11: no active line means no active output
  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (devIrq == '0) |-> (intOut == 4'b0000));

endmodule

bind pcihb_regif pcihb_checker #(.ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV)) i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .busReady (busReady),
  .cfgReq   (cfgReq),
  .cfgAddr  (cfgAddr),
  .cfgAck   (cfgAck),
  .cfgRdata (cfgRdata),
  .devIrq   (devIrq),
  .intOut   (intOut)
);

// File: tb/test_pcihb_regif.sv
`timescale 1ns/1ps
module test_pcihb_regif;

  localparam int          ADDR_W  = 10;
  localparam int          NUM_DEV = 6;
  localparam logic [15:0] VID     = 16'h1DE5;
  localparam logic [15:0] DID     = 16'hC0DE;
  localparam time         HALF    = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic busReady, cfgReq, cfgWrite;
  logic [31:0] cfgAddr, cfgWdata;
  logic cfgAck = 1'b0;
  logic [31:0] cfgRdata = '0;
  logic [31:0] winAddr = '0;
  logic winHit;
  logic [17:0] winOffset;
  logic [8*NUM_DEV-1:0] devIrq = '0;
  logic [3:0] intOut;

  int vecs = 0, errs = 0;
  int ackDelay = 0;
  logic [31:0] respData = '0, seenAddr = '0, seenWdata = '0;
  logic seenWr = 1'b0;

  always #HALF clk = ~clk;

  pcihb_regif #(.ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV), .VENDOR_ID(VID), .DEVICE_ID(DID))
  i_pcihb_regif (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady),
    .cfgReq(cfgReq), .cfgWrite(cfgWrite), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgAck(cfgAck), .cfgRdata(cfgRdata), .winAddr(winAddr), .winHit(winHit),
    .winOffset(winOffset), .devIrq(devIrq), .intOut(intOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // PCI-side responder: acknowledges after ackDelay waiting cycles
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      if (cfgAck) cfgAck = 1'b0;
      else if (cfgReq) begin
        if (waitCnt == ackDelay) begin
          cfgAck    = 1'b1;
          cfgRdata  = respData;
          seenAddr  = cfgAddr;
          seenWr    = cfgWrite;
          seenWdata = cfgWdata;
          waitCnt   = 0;
        end else waitCnt++;
      end
    end
  end

  task automatic busAccess(input logic wr, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                           output logic [31:0] rd, output int lat);
    @(negedge clk);
    busSel = 1'b1; busWrite = wr; busAddr = a; busWdata = d;
    lat = 0;
    #1;
    while (!busReady) begin
      @(posedge clk); @(negedge clk); #1;
      lat++;
    end
    rd = busRdata;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic wr32(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    logic [31:0] rd; int lat;
    busAccess(1'b1, a, d, rd, lat);
  endtask

  task automatic rd32(input logic [ADDR_W-1:0] a, output logic [31:0] d, output int lat);
    busAccess(1'b0, a, '0, d, lat);
  endtask

  task automatic t_reset();
    logic [31:0] d; int lat;
    @(negedge clk);
    check("R1 cfgReq idle", {31'b0, cfgReq}, 32'h0);
    rd32(10'h1C0, d, lat); check("R1 pointer", d, 32'h0);
    rd32(10'h1C4, d, lat); check("R1 memory base", d, 32'h0);
    rd32(10'h1C8, d, lat); check("R1 I/O base", d, 32'hFE24_0000);
    rd32(10'h000, d, lat); check("R1 id word", d, {DID, VID});
    rd32(10'h004, d, lat); check("R1 command/status", d, 32'h0290_0080);
    check("R8 immediate ready", lat, 0);
  endtask

  task automatic t_header();
    logic [31:0] d; int lat;
    wr32(10'h0FC, 32'hDEAD_BEEF);
    wr32(10'h010, 32'h1234_5678);
    rd32(10'h0FC, d, lat); check("R2 last header word", d, 32'hDEAD_BEEF);
    rd32(10'h010, d, lat); check("R2 header word 4", d, 32'h1234_5678);
    check("R8 header read latency", lat, 0);
  endtask

  task automatic t_control();
    logic [31:0] d; int lat;
    wr32(10'h1C0, 32'hA5A5_5A5B); rd32(10'h1C0, d, lat); check("R3 pointer all bits", d, 32'hA5A5_5A5B);
    wr32(10'h1C4, 32'hFFFF_FFFF); rd32(10'h1C4, d, lat); check("R4 memory base ones", d, 32'hFF00_0001);
    wr32(10'h1C4, 32'hABCD_EF12); rd32(10'h1C4, d, lat); check("R4 memory base pattern", d, 32'hAB00_0000);
    wr32(10'h1C8, 32'hFFFF_FFFF); rd32(10'h1C8, d, lat); check("R5 I/O base ones", d, 32'hFFFC_0001);
  endtask

  task automatic t_undecoded();
    logic [31:0] d; int lat;
    wr32(10'h1C0, 32'h0000_1111);
    wr32(10'h100, 32'hFFFF_FFFF);
    wr32(10'h1C2, 32'hFFFF_FFFF);
    wr32(10'h1CC, 32'hFFFF_FFFF);
    wr32(10'h224, 32'hFFFF_FFFF);
    rd32(10'h000, d, lat); check("R9 header untouched by 0x100", d, {DID, VID});
    rd32(10'h1C0, d, lat); check("R9 pointer untouched", d, 32'h0000_1111);
    rd32(10'h100, d, lat); check("R9 hole reads zero", d, 32'h0);
    rd32(10'h1C2, d, lat); check("R9 misaligned reads zero", d, 32'h0);
    rd32(10'h300, d, lat); check("R9 high reads zero", d, 32'h0);
    rd32(10'h222, d, lat); check("R8 misaligned port latency", lat, 0);
  endtask

  task automatic t_port();
    logic [31:0] d; int lat;
    wr32(10'h1C0, 32'h8000_1234);
    ackDelay = 3;
    busAccess(1'b1, 10'h220, 32'hCAFE_F00D, d, lat);
    check("R6 write address", seenAddr, 32'h8000_1234);
    check("R6 write direction", {31'b0, seenWr}, 32'h1);
    check("R6 write data", seenWdata, 32'hCAFE_F00D);
    check("R7 write latency", lat, 5);
    ackDelay = 0;
    respData = 32'h1357_2468;
    wr32(10'h1C0, 32'h8000_0008);
    rd32(10'h220, d, lat);
    check("R6 read address", seenAddr, 32'h8000_0008);
    check("R6 read direction", {31'b0, seenWr}, 32'h0);
    check("R7 read data", d, 32'h1357_2468);
    check("R7 read latency", lat, 2);
  endtask

  task automatic t_window();
    wr32(10'h1C8, 32'hFE24_0000);
    winAddr = 32'hFE24_0000; #1;
    check("R10 base hit", {31'b0, winHit}, 32'h1);
    check("R10 base offset", {14'b0, winOffset}, 32'h0);
    winAddr = 32'hFE27_FFFC; #1;
    check("R10 top hit", {31'b0, winHit}, 32'h1);
    check("R10 top offset", {14'b0, winOffset}, 32'h0003_FFFC);
    winAddr = 32'hFE28_0000; #1; check("R10 above miss", {31'b0, winHit}, 32'h0);
    winAddr = 32'hFE23_FFFF; #1; check("R10 below miss", {31'b0, winHit}, 32'h0);
    wr32(10'h1C8, 32'h1234_5677);
    winAddr = 32'h1235_0040; #1;
    check("R10 moved hit", {31'b0, winHit}, 32'h1);
    check("R10 moved offset", {14'b0, winOffset}, 32'h0001_0040);
    winAddr = 32'hFE24_0000; #1; check("R10 old base miss", {31'b0, winHit}, 32'h0);
  endtask

  task automatic t_irq();
    devIrq = '0; devIrq[2] = 1'b1; #1;
    check("R11 dev0 fn2", {28'b0, intOut}, 32'h1);
    devIrq = '0; devIrq[29] = 1'b1; #1;
    check("R11 dev3 fn5", {28'b0, intOut}, 32'h8);
    devIrq = '0; devIrq[43] = 1'b1; #1;
    check("R11 dev5 wraps to 1", {28'b0, intOut}, 32'h2);
    devIrq = '0; devIrq[32] = 1'b1; devIrq[6] = 1'b1; #1;
    check("R11 dev4 and dev0 share 0", {28'b0, intOut}, 32'h1);
    devIrq = '0; #1;
    check("R11 quiet", {28'b0, intOut}, 32'h0);
  endtask

  initial begin
    #(HALF * 2 * 100000);
    errs++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_header();
    t_control();
    t_undecoded();
    t_port();
    t_window();
    t_irq();
    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule